// File: doc/BRIEF.md
# Stop-Mode Clock and Wake Controller

This block governs the deepest power-saving state of a small microcontroller clock system. Software writes a control bit to request the stopped state. If the PLL has already been disabled and powered down, the controller gates every clock source off: the main oscillator, the subclock oscillator and the PLL. It also halts the bus clock and the peripheral clocks. If the PLL is not yet safe, the request is refused and a one-cycle reject flag is raised.

The stopped state ends on a synchronous reset or on a qualified interrupt. The wake qualification runs without a clock. It is then brought through a two-flop synchroniser. After that, a programmable settling count lets the oscillators stabilise before the bus and peripheral clocks return. The bus clock comes back on the source that was selected before stop. If that source was the main clock, it comes back divided by 8, because the divider field is forced to that setting on entry.

While stopped, the block also overrides the bus-control pins and the clock-output pin to their hold levels.

Top module: `clkstop_ctrl`

## Requirements
- R1: A write to address 0 with data bit 0 = 1 enters stop mode at that clock edge when the PLL control register bit 7 is 0 and the PLL power-down bit is 1; `stop_q` reads 1 from then on, and a write with bit 0 = 0 has no effect on the clocks.
- R2: In stop mode `main_en`, `sub_en`, `pll_on`, `bclk_en` and `periph_en` are all 0; in normal running all but `pll_on` are 1, and `pll_on` equals PLL control bit 7.
- R3: On entry, the divider register (address 1) keeps its upper three bits, and its lower five bits become 01000 (divide by 8).
- R4: A stop request made while PLL bit 7 is 1 or the power-down bit (address 3, bit 0) is 0 is ignored: `stop_q` stays 0, the clocks keep running, and `stop_reject` is 1 for exactly one cycle.
- R5: Reset in any state returns the block to running with `stop_q` = 0, the divider, PLL control and power-down registers at 0, and all pin outputs at 0.
- R6: An interrupt wakes the block only when `ie_flag` = 1 and `irq_prio` is strictly greater than `exit_lvl`; an equal or lower priority, or a cleared enable, leaves the block stopped.
- R7: `bclk_src` follows `sub_sel` while running and is frozen through stop and settling, so the bus clock resumes on the source selected before stop.
- R8: While stopped with `ext_mode` = 1, `ctl_out` is all ones one cycle after each stopped cycle; otherwise it is a one-cycle registered copy of `ctl_in`.
- R9: While stopped, `clkout_out` is 1 when `clkout_sel` = 0 (undivided) and holds its last value when `clkout_sel` is 1, 2 or 3 (divided).
- R10: `stop_q` clears by itself on an interrupt wake-up.
- R11: After a wake-up, `main_en` and `sub_en` are 1 while `bclk_en` and `periph_en` stay 0 for `settle_len`+1 cycles, then all return to 1.
- R12: An interrupt presented before edge e clears `stop_q` at edge e+2 (two synchroniser flops, then the state change).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 stop control, 1 divider, 2 PLL control, 3 PLL power |
| wr_data | input | 8 | Write data |
| sub_sel | input | 1 | 1 selects the subclock as bus-clock source |
| irq_req | input | 1 | Peripheral interrupt request |
| irq_prio | input | PRIO_W | Priority of the request |
| exit_lvl | input | PRIO_W | Exit-priority level for wake |
| ie_flag | input | 1 | Global interrupt enable |
| settle_len | input | CNT_W | Oscillator settling length in cycles |
| ext_mode | input | 1 | 1 for external-bus operating modes |
| clkout_sel | input | 2 | Clock-output selection, 0 undivided |
| ctl_in | input | CTL_W | Normal bus-control pin levels |
| clkout_in | input | 1 | Normal clock-output pin level |
| main_en | output | 1 | Main oscillator enable |
| sub_en | output | 1 | Subclock oscillator enable |
| pll_on | output | 1 | PLL enable |
| bclk_en | output | 1 | Bus-clock gate enable |
| periph_en | output | 1 | Peripheral-clock gate enable |
| bclk_src | output | 1 | Bus-clock source, 1 subclock |
| div_q | output | 8 | Divider register |
| stop_q | output | 1 | Stop control bit |
| stop_reject | output | 1 | Refused stop request pulse |
| ctl_out | output | CTL_W | Bus-control pin levels after override |
| clkout_out | output | 1 | Clock-output pin level after override |

## Verification
A register write takes effect at the edge it is presented to: `stop_q`, `div_q`, `stop_reject` and the enables change that edge. The pin overrides react one edge after a stopped cycle. An interrupt clears `stop_q` two edges after it is presented, and `bclk_en` follows `settle_len`+1 edges later. The bench drives inputs on falling edges and updates its model on rising edges. It compares every output on the next falling edge, and it adds directed checks that count these exact edge offsets.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    CS_RUN    = 2'd0,
    CS_STOP   = 2'd1,
    CS_SETTLE = 2'd2
  } cs_state_t;

  localparam logic [1:0] A_STOPCTL = 2'd0;
  localparam logic [1:0] A_DIV     = 2'd1;
  localparam logic [1:0] A_PLL     = 2'd2;
  localparam logic [1:0] A_PLLPWR  = 2'd3;

  localparam logic [4:0] DIV8_LOW  = 5'b01000;
endpackage

// File: rtl/cs_wake_qual.sv
module cs_wake_qual #(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              irq_req,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0] exit_lvl,
  input  logic              ie_flag,
  output logic              wake
);
  logic raw;
  logic meta_q, sync_q;

  // unclocked qualification; sampled only by the synchroniser
  assign raw = ie_flag && irq_req && (irq_prio > exit_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= arm && raw;
      sync_q <= arm && meta_q;
    end
  end

  assign wake = sync_q;
endmodule

// File: rtl/cs_settle_cnt.sv
module cs_settle_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= len;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/cs_pin_hold.sv
module cs_pin_hold #(
  parameter int CTL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stopped,
  input  logic             ext_mode,
  input  logic [1:0]       clkout_sel,
  input  logic [CTL_W-1:0] ctl_in,
  input  logic             clkout_in,
  output logic [CTL_W-1:0] ctl_out,
  output logic             clkout_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_out    <= '0;
      clkout_out <= 1'b0;
    end else begin
      ctl_out <= (stopped && ext_mode) ? {CTL_W{1'b1}} : ctl_in;
      if (!stopped)               clkout_out <= clkout_in;
      else if (clkout_sel == 2'd0) clkout_out <= 1'b1;
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 12,
  parameter int CTL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sub_sel,
  input  logic              irq_req,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0] exit_lvl,
  input  logic              ie_flag,
  input  logic [CNT_W-1:0]  settle_len,
  input  logic              ext_mode,
  input  logic [1:0]        clkout_sel,
  input  logic [CTL_W-1:0]  ctl_in,
  input  logic              clkout_in,
  output logic              main_en,
  output logic              sub_en,
  output logic              pll_on,
  output logic              bclk_en,
  output logic              periph_en,
  output logic              bclk_src,
  output logic [7:0]        div_q,
  output logic              stop_q,
  output logic              stop_reject,
  output logic [CTL_W-1:0]  ctl_out,
  output logic              clkout_out
);
  cs_state_t st_q;
  logic [7:0] pll_ctl_q;
  logic       pll_pd_q;
  logic       wake, settle_done;
  logic       is_run, is_stop, is_settle;
  logic       stop_wr, pll_safe;

  assign is_run    = (st_q == CS_RUN);
  assign is_stop   = (st_q == CS_STOP);
  assign is_settle = (st_q == CS_SETTLE);
  assign stop_wr   = is_run && wr_en && (wr_addr == A_STOPCTL) && wr_data[0];
  assign pll_safe  = !pll_ctl_q[7] && pll_pd_q;

  cs_wake_qual #(.PRIO_W(PRIO_W)) u_wake (
    .clk(clk), .rst(rst), .arm(is_stop),
    .irq_req(irq_req), .irq_prio(irq_prio), .exit_lvl(exit_lvl),
    .ie_flag(ie_flag), .wake(wake)
  );

  cs_settle_cnt #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst(rst), .load(is_stop && wake), .len(settle_len),
    .run(is_settle), .done(settle_done)
  );

  cs_pin_hold #(.CTL_W(CTL_W)) u_pins (
    .clk(clk), .rst(rst), .stopped(is_stop), .ext_mode(ext_mode),
    .clkout_sel(clkout_sel), .ctl_in(ctl_in), .clkout_in(clkout_in),
    .ctl_out(ctl_out), .clkout_out(clkout_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= CS_RUN;
      stop_q      <= 1'b0;
      stop_reject <= 1'b0;
      div_q       <= '0;
      pll_ctl_q   <= '0;
      pll_pd_q    <= 1'b0;
      bclk_src    <= 1'b0;
    end else begin
      stop_reject <= 1'b0;
      unique case (st_q)
        CS_RUN: begin
          bclk_src <= sub_sel;
          if (stop_wr) begin
            if (pll_safe) begin
              st_q   <= CS_STOP;
              stop_q <= 1'b1;
              div_q  <= {div_q[7:5], DIV8_LOW};
            end else begin
              stop_reject <= 1'b1;
            end
          end else if (wr_en) begin
            case (wr_addr)
              A_DIV:    div_q     <= wr_data;
              A_PLL:    pll_ctl_q <= wr_data;
              A_PLLPWR: pll_pd_q  <= wr_data[0];
              default:  ;
            endcase
          end
        end
        CS_STOP: begin
          if (wake) begin
            st_q   <= CS_SETTLE;
            stop_q <= 1'b0;
          end
        end
        CS_SETTLE: begin
          if (settle_done) st_q <= CS_RUN;
        end
        default: st_q <= CS_RUN;
      endcase
    end
  end

  assign main_en   = !is_stop;
  assign sub_en    = !is_stop;
  assign bclk_en   = is_run;
  assign periph_en = is_run;
  assign pll_on    = is_run && pll_ctl_q[7];
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int CTL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_mode,
  input logic             main_en,
  input logic             sub_en,
  input logic             pll_on,
  input logic             bclk_en,
  input logic             periph_en,
  input logic             bclk_src,
  input logic [7:0]       div_q,
  input logic             stop_q,
  input logic             stop_reject,
  input logic [CTL_W-1:0] ctl_out
);
  p_gated_r2: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> !main_en && !sub_en && !pll_on && !bclk_en && !periph_en);

  p_div8_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_q) |-> div_q[4:0] == 5'b01000);

  p_reject_r4: assert property (@(posedge clk) disable iff (rst)
    stop_reject |-> !stop_q && bclk_en);

  p_src_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    $past(stop_q) && stop_q |-> $stable(bclk_src));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $past(stop_q) && $past(ext_mode) |-> ctl_out == {CTL_W{1'b1}});

  p_settle_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_q) && !$past(rst) |-> main_en && sub_en && !bclk_en && !periph_en);
endmodule

bind clkstop_ctrl clkstop_chk #(.CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst(rst), .ext_mode(ext_mode), .main_en(main_en),
  .sub_en(sub_en), .pll_on(pll_on), .bclk_en(bclk_en),
  .periph_en(periph_en), .bclk_src(bclk_src), .div_q(div_q),
  .stop_q(stop_q), .stop_reject(stop_reject), .ctl_out(ctl_out)
);

// File: tb/sim_clkstop_ctrl.sv
module sim_clkstop_ctrl;
  localparam int PERIOD = 10;
  localparam int CTL_W = 4;

  logic clk = 0, rst = 1;
  logic wr_en = 0; logic [1:0] wr_addr = 0; logic [7:0] wr_data = 0;
  logic sub_sel = 0, irq_req = 0, ie_flag = 0, ext_mode = 0, clkout_in = 0;
  logic [2:0] irq_prio = 0, exit_lvl = 0;
  logic [11:0] settle_len = 0;
  logic [1:0] clkout_sel = 0;
  logic [CTL_W-1:0] ctl_in = 0;
  logic main_en, sub_en, pll_on, bclk_en, periph_en, bclk_src, stop_q, stop_reject, clkout_out;
  logic [7:0] div_q;
  logic [CTL_W-1:0] ctl_out;

  int checks = 0, failures = 0;
  bit cmp_on = 0;

  always #(PERIOD/2) clk = ~clk;

  clkstop_ctrl u0 (.*);

  // behavioural reference: mode 0 running, 1 stopped, 2 settling
  int m_mode = 0, m_cnt = 0;
  bit m_stop = 0, m_rej = 0, m_src = 0, m_pd = 0, m_clko = 0;
  bit [7:0] m_div = 0, m_pll = 0;
  bit [CTL_W-1:0] m_ctl = 0;
  bit m_w[$];

  always @(posedge clk) begin
    int pm;
    bit qual, arrived;
    pm = m_mode;
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_stop = 0; m_rej = 0; m_src = 0; m_pd = 0;
      m_clko = 0; m_div = 0; m_pll = 0; m_ctl = 0; m_w = {0, 0};
    end else begin
      qual = ie_flag && irq_req && (irq_prio > exit_lvl);
      arrived = m_w.pop_front();
      m_w.push_back(pm == 1 && qual);
      if (pm != 1) begin m_w = {0, 0}; end
      m_ctl = (pm == 1 && ext_mode) ? '1 : ctl_in;
      if (pm != 1) m_clko = clkout_in; else if (clkout_sel == 0) m_clko = 1;
      m_rej = 0;
      if (pm == 0) begin
        m_src = sub_sel;
        if (wr_en && wr_addr == 0 && wr_data[0]) begin
          if (!m_pll[7] && m_pd) begin
            m_mode = 1; m_stop = 1; m_div = {m_div[7:5], 5'b01000};
          end else m_rej = 1;
        end else if (wr_en && wr_addr == 1) m_div = wr_data;
        else if (wr_en && wr_addr == 2) m_pll = wr_data;
        else if (wr_en && wr_addr == 3) m_pd = wr_data[0];
      end else if (pm == 1) begin
        if (arrived) begin m_mode = 2; m_stop = 0; m_cnt = settle_len; end
      end else begin
        if (m_cnt == 0) m_mode = 0; else m_cnt--;
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R1 stop_q", stop_q, m_stop);
    chk("R2 main_en", main_en, m_mode != 1);
    chk("R2 sub_en", sub_en, m_mode != 1);
    chk("R2 pll_on", pll_on, m_mode == 0 && m_pll[7]);
    chk("R11 bclk_en", bclk_en, m_mode == 0);
    chk("R11 periph_en", periph_en, m_mode == 0);
    chk("R3 div_q", div_q, m_div);
    chk("R4 stop_reject", stop_reject, m_rej);
    chk("R7 bclk_src", bclk_src, m_src);
    chk("R8 ctl_out", ctl_out, m_ctl);
    chk("R9 clkout_out", clkout_out, m_clko);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // interrupt wake with directed edge counting (settle_len = 5)
  task automatic wake_irq();
    @(negedge clk); irq_req = 1; ie_flag = 1; irq_prio = 5; exit_lvl = 3;
    @(negedge clk); chk("R12 still stopped e", stop_q, 1);
    @(negedge clk); chk("R12 still stopped e+1", stop_q, 1);
    @(negedge clk); chk("R10 self-clear e+2", stop_q, 0);
    irq_req = 0;
    cyc(5); chk("R11 bus gated in settle", bclk_en, 0);
    chk("R11 osc on in settle", main_en, 1);
    cyc(1); chk("R11 bus back", bclk_en, 1);
  endtask

  initial begin
    settle_len = 5;
    repeat (3) @(negedge clk);
    rst = 0; cmp_on = 1;
    chk("R5 reset stop_q", stop_q, 0);
    chk("R5 reset div", div_q, 0);
    chk("R5 reset bclk_en", bclk_en, 1);
    wr(1, 8'hE5);
    wr(2, 8'h80);
    wr(3, 8'h01);
    wr(0, 8'h01); chk("R4 rejected with pll on", stop_q, 0);
    wr(2, 8'h00); wr(3, 8'h00);
    wr(0, 8'h01); chk("R4 rejected pd=0", stop_q, 0);
    wr(0, 8'h00); chk("R1 zero write no effect", bclk_en, 1);
    wr(3, 8'h01);
    ext_mode = 1; clkout_sel = 0; ctl_in = 4'h5; clkout_in = 0; sub_sel = 0;
    wr(0, 8'h01);
    chk("R1 stopped", stop_q, 1);
    chk("R3 div forced", div_q, 8'hE8);
    cyc(2);
    chk("R8 pins high", ctl_out, 4'hF);
    chk("R9 undivided high", clkout_out, 1);
    // unqualified requests
    ie_flag = 1; irq_req = 1; irq_prio = 3; exit_lvl = 3; cyc(6);
    chk("R6 equal prio stays", stop_q, 1);
    ie_flag = 0; irq_prio = 7; cyc(6);
    chk("R6 ie=0 stays", stop_q, 1);
    irq_req = 0; ie_flag = 0;
    wake_irq();
    chk("R7 main source", bclk_src, 0);
    chk("R3 div8 kept", div_q, 8'hE8);
    // second round: subclock, internal mode, divided clock output
    sub_sel = 1; ext_mode = 0; clkout_sel = 2; clkout_in = 1; ctl_in = 4'h3;
    cyc(2);
    wr(0, 8'h01);
    clkout_in = 0; sub_sel = 0; cyc(3);
    chk("R9 divided holds", clkout_out, 1);
    chk("R8 internal passthrough", ctl_out, 4'h3);
    chk("R7 frozen", bclk_src, 1);
    sub_sel = 1;
    wake_irq();
    chk("R7 sub source", bclk_src, 1);
    // third round: wake by reset
    wr(0, 8'h01);
    chk("R1 stopped again", stop_q, 1);
    cyc(4);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R5 reset wake", stop_q, 0);
    chk("R5 reset clocks", bclk_en, 1);
    chk("R5 reset pins", ctl_out, 0);
    cyc(4);
    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule